// File: doc/BRIEF.md
# Two-Wire Serial Slave Bus Front End

This block is the bus side of a serial memory slave on a two-wire open-drain bus. It runs on a system clock many times faster than the bus clock. Both bus lines are brought into that clock domain through a synchronizer and a three-sample majority vote. The block then finds start and stop conditions and moves 8-bit words across the bus, most significant bit first. Incoming bits are taken on rising bus-clock edges, and outgoing bits change only while the bus clock is low. The slave acknowledges a word by pulling the data line low during the ninth clock. The data output is a single pull-low enable and never drives the line high.

The first word after every start is the device word. Its top bit must be 1. Its next three bits must match the select straps, with the middle strap inverted before the compare. The three bits after the select field are not part of the match; they are passed on as the upper memory-address bits. The last bit chooses read (1) or write (0). On a match, the block reports the direction and the block bits to a memory controller. After that it hands each written byte to the controller, or it fetches each read byte from the controller at the moment that byte is due on the bus.

Top module: `tws_frontend`

## Requirements
- R1: A falling data line while the clock line is high is a start and gives a one-cycle `bus_start` pulse. A rising data line while the clock line is high is a stop and gives a one-cycle `bus_stop` pulse. Data changes while the clock line is low are neither.
- R2: The device word (bit 7 first on the wire) matches when bit 7 is 1 and bits 6:4 equal {`strap_sel[2]`, not `strap_sel[1]`, `strap_sel[0]`}. On a match, `sda_oe` is 1 through the ninth clock high time.
- R3: On a device-word mismatch, including bit 7 = 0, the block gives no acknowledge. It then ignores the bus (no acknowledge, no `rx_valid`) until the next start.
- R4: An accepted device word gives one `dev_ok` pulse, with `dev_blk` equal to word bits 3:1 and `dev_rd` equal to word bit 0.
- R5: After an accepted write device word, each further 8-bit word is taken MSB first on clock rising edges. It is presented on `rx_byte` with a one-cycle `rx_valid` pulse and is acknowledged in the ninth clock.
- R6: After an accepted read device word, `tx_byte` is sent MSB first: `sda_oe` is the inverse of the current bit. `sda_oe` does not change while the clock line is high, except when a start or stop resets it.
- R7: During a read, a master acknowledge (data low in the ninth clock) causes a `tx_load` pulse and the next `tx_byte` to be sent. A master non-acknowledge releases the line, and the block does not drive it again before the next start.
- R8: After a stop, the block does not acknowledge any word until a new start.
- R9: A start in the middle of a word abandons that word and begins device-word reception again.
- R10: A data-line pulse one system clock long while the clock line is high produces neither a start nor a stop.
- R11: During and right after reset, `sda_oe`, `rx_valid`, `dev_ok` and `tx_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than the bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_sel | input | 3 | Strapped select pins |
| tx_byte | input | 8 | Read data from the memory controller, captured on `tx_load` |
| dev_ok | output | 1 | One-cycle pulse: device word accepted |
| dev_rd | output | 1 | Direction of the last accepted device word, 1 = read |
| dev_blk | output | 3 | Upper address bits from the last accepted device word |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` holds a newly written word |
| rx_byte | output | 8 | Last written data word |
| tx_load | output | 1 | One-cycle pulse: `tx_byte` sampled for transmission |
| bus_start | output | 1 | One-cycle pulse per start condition |
| bus_stop | output | 1 | One-cycle pulse per stop condition |

## Verification
A wrong bit counter or a bad match compare shows in the ninth clock of the same word: the acknowledge is missing or appears where it should not. A lost read state shows as wrong bits on the data line within the next word. The filter and the condition detector are seen through the start and stop pulses, which appear a few system clocks after the bus change. A broken filter therefore shows as an extra pulse during a glitch.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACKF
  } tws_state_e;
endpackage

// File: rtl/tws_line_filt.sv
module tws_line_filt #(
  parameter int   STAGES  = 2,
  parameter int   TAPS    = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(TAPS + 1);

  logic [STAGES-1:0] sync_q;
  logic [TAPS-1:0]   win_q;
  logic              dout_q;
  logic [CW-1:0]     ones;
  logic              vote;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CW'(win_q[i]);
    vote = (ones > CW'(TAPS / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      win_q  <= {TAPS{RST_VAL}};
      dout_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      win_q  <= {win_q[TAPS-2:0], sync_q[STAGES-1]};
      dout_q <= vote;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/tws_cond_det.sv
module tws_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/tws_byte_fsm.sv
module tws_byte_fsm
  import tws_pkg::*;
#(
  parameter int               SEL_W    = 3,
  parameter int               BLK_W    = 3,
  parameter int               WORD_W   = 2 + SEL_W + BLK_W,
  parameter logic [SEL_W-1:0] INV_MASK = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_f,
  input  logic [SEL_W-1:0]  strap_sel,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              dev_ok,
  output logic              dev_rd,
  output logic [BLK_W-1:0]  dev_blk,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              bus_start,
  output logic              bus_stop
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  tws_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, rxb_q, rxb_d;
  logic              first_q, first_d, rd_q, rd_d, oe_q, oe_d;
  logic              dok_q, dok_d, drd_q, drd_d, rxv_q, rxv_d;
  logic              txl_q, txl_d, bst_q, bst_d, bsp_q, bsp_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic              hit;

  assign hit = sh_q[WORD_W-1] &&
               (sh_q[WORD_W-2 -: SEL_W] == (strap_sel ^ INV_MASK));

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; first_d = first_q;
    rd_d = rd_q; oe_d = oe_q; drd_d = drd_q; blk_d = blk_q; rxb_d = rxb_q;
    dok_d = 1'b0; rxv_d = 1'b0; txl_d = 1'b0; bst_d = 1'b0; bsp_d = 1'b0;
    if (stop_c) begin
      state_d = ST_IDLE; oe_d = 1'b0; bsp_d = 1'b1;
    end else if (start_c) begin
      state_d = ST_RX; cnt_d = '0; first_d = 1'b1; rd_d = 1'b0;
      oe_d = 1'b0; bst_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_RX: if (scl_rise) begin
          sh_d  = {sh_q[WORD_W-2:0], sda_f};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_RXEND;
        end
        ST_RXEND: if (scl_fall) begin
          if (first_q) begin
            if (hit) begin
              oe_d = 1'b1; dok_d = 1'b1; first_d = 1'b0;
              drd_d = sh_q[0]; rd_d = sh_q[0];
              blk_d = sh_q[1 +: BLK_W];
              state_d = ST_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            rxv_d = 1'b1; rxb_d = sh_q; oe_d = 1'b1; state_d = ST_ACK;
          end
        end
        ST_ACK: if (scl_fall) begin
          cnt_d = '0;
          if (rd_q) begin
            sh_d = tx_byte; txl_d = 1'b1;
            oe_d = ~tx_byte[WORD_W-1]; state_d = ST_TX;
          end else begin
            oe_d = 1'b0; state_d = ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == LAST) begin
            oe_d = 1'b0; state_d = ST_MACK;
          end else begin
            sh_d  = {sh_q[WORD_W-2:0], 1'b0};
            oe_d  = ~sh_q[WORD_W-2];
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_MACK: if (scl_rise) state_d = sda_f ? ST_IDLE : ST_MACKF;
        ST_MACKF: if (scl_fall) begin
          sh_d = tx_byte; txl_d = 1'b1; cnt_d = '0;
          oe_d = ~tx_byte[WORD_W-1]; state_d = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rxb_q <= '0;
      first_q <= 1'b0; rd_q <= 1'b0; oe_q <= 1'b0; dok_q <= 1'b0;
      drd_q <= 1'b0; blk_q <= '0; rxv_q <= 1'b0; txl_q <= 1'b0;
      bst_q <= 1'b0; bsp_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; rxb_q <= rxb_d;
      first_q <= first_d; rd_q <= rd_d; oe_q <= oe_d; dok_q <= dok_d;
      drd_q <= drd_d; blk_q <= blk_d; rxv_q <= rxv_d; txl_q <= txl_d;
      bst_q <= bst_d; bsp_q <= bsp_d;
    end
  end

  assign sda_oe    = oe_q;
  assign dev_ok    = dok_q;
  assign dev_rd    = drd_q;
  assign dev_blk   = blk_q;
  assign rx_valid  = rxv_q;
  assign rx_byte   = rxb_q;
  assign tx_load   = txl_q;
  assign bus_start = bst_q;
  assign bus_stop  = bsp_q;
endmodule

// File: rtl/tws_frontend.sv
module tws_frontend #(
  parameter int               SEL_W    = 3,
  parameter int               BLK_W    = 3,
  parameter int               WORD_W   = 2 + SEL_W + BLK_W,
  parameter int               STAGES   = 2,
  parameter int               TAPS     = 3,
  parameter logic [SEL_W-1:0] INV_MASK = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  strap_sel,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              dev_ok,
  output logic              dev_rd,
  output logic [BLK_W-1:0]  dev_blk,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              bus_start,
  output logic              bus_stop
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, filt;
  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

  assign raw   = {sda_in, scl_in};
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tws_line_filt #(.STAGES(STAGES), .TAPS(TAPS), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .dout(filt[g])
    );
  end

  tws_cond_det u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  tws_byte_fsm #(
    .SEL_W(SEL_W), .BLK_W(BLK_W), .WORD_W(WORD_W), .INV_MASK(INV_MASK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_f(sda_f),
    .strap_sel(strap_sel), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .dev_ok(dev_ok), .dev_rd(dev_rd), .dev_blk(dev_blk),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_c,
  input logic stop_c,
  input logic sda_oe,
  input logic rx_valid,
  input logic dev_ok,
  input logic dev_rd,
  input logic tx_load,
  input logic bus_stop
);
  // R6: the pull-low enable moves only in the low clock phase
  assert_oe_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_f);

  // R5: one pulse per received word
  assert_rxv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: device acceptance and data delivery never coincide
  assert_devok_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_ok && rx_valid));

  // R8: a stop leaves the line released
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> !sda_oe);

  // R7: fetches only happen in read direction
  assert_txload_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> dev_rd);
endmodule

bind tws_frontend tws_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_c(start_c),
  .stop_c(stop_c), .sda_oe(sda_oe), .rx_valid(rx_valid), .dev_ok(dev_ok),
  .dev_rd(dev_rd), .tx_load(tx_load), .bus_stop(bus_stop)
);

// File: tb/tb_tws_frontend.sv
module tb_tws_frontend;
  localparam int HALF = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b000;
  logic [7:0] txb = 8'h00;
  logic sda_oe, dev_ok, dev_rd, rx_valid, tx_load, bus_start, bus_stop;
  logic [2:0] dev_blk;
  logic [7:0] rx_byte;
  wire  sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_rx = 0, n_dok = 0, n_txl = 0;
  logic [7:0] last_rx = 8'h00;
  logic [2:0] last_blk = 3'b000;
  logic last_rd = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tws_frontend dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap_sel(strap), .tx_byte(txb), .dev_ok(dev_ok),
    .dev_rd(dev_rd), .dev_blk(dev_blk), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_load(tx_load), .bus_start(bus_start),
    .bus_stop(bus_stop)
  );

  always @(negedge clk) begin
    if (bus_start) n_start++;
    if (bus_stop)  n_stop++;
    if (tx_load)   n_txl++;
    if (rx_valid) begin n_rx++; last_rx = rx_byte; end
    if (dev_ok) begin n_dok++; last_blk = dev_blk; last_rd = dev_rd; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(4);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF / 2);
    ack = sda_oe; tick(HALF / 2); scl_m = 1'b0; tick(4);
  endtask

  task automatic read_byte(input bit m_ack, output logic [7:0] d, output bit stable);
    stable = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic o1;
      tick(HALF); scl_m = 1'b1; tick(2); o1 = sda_oe;
      tick(HALF / 2); d[i] = sda_line;
      tick(HALF - 2 - HALF / 2);
      if (sda_oe !== o1) stable = 1'b0;
      scl_m = 1'b0; tick(4);
    end
    sda_m = m_ack ? 1'b0 : 1'b1;
    tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(4); sda_m = 1'b1;
  endtask

  // {strap, device word, data word, expect acknowledge}
  localparam logic [19:0] VEC [6] = '{
    {3'b000, 8'hAA, 8'h5A, 1'b1},
    {3'b010, 8'h86, 8'hC1, 1'b1},
    {3'b101, 8'hF0, 8'h0F, 1'b1},
    {3'b000, 8'h80, 8'h77, 1'b0},
    {3'b000, 8'h20, 8'h99, 1'b0},
    {3'b111, 8'hDE, 8'hE7, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    bit st;
    int s0, r0, t0;
    tick(5);
    // R11 reset state
    chk(sda_oe == 0 && rx_valid == 0 && dev_ok == 0 && tx_load == 0, "R11 reset outputs", {sda_oe, rx_valid, dev_ok, tx_load}, 0);
    rst_n = 1'b1; tick(10);
    chk(sda_oe == 0 && rx_valid == 0, "R11 after release", {sda_oe, rx_valid}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [19:0] e;
      e = VEC[v];
      strap = e[19:17];
      s0 = n_start; r0 = n_rx;
      do_start();
      chk(n_start == s0 + 1, "R1 start pulse", n_start - s0, 1);
      send_byte(e[16:9], ack);
      chk(ack == e[0], e[0] ? "R2 device acknowledge" : "R3 device rejected", ack, e[0]);
      if (e[0]) begin
        chk(last_blk == e[12:10] && last_rd == 1'b0, "R4 block bits and direction", {last_blk, last_rd}, {e[12:10], 1'b0});
        send_byte(e[8:1], ack);
        chk(ack == 1'b1 && n_rx == r0 + 1 && last_rx == e[8:1], "R5 write word", last_rx, e[8:1]);
      end else begin
        send_byte(e[8:1], ack);
        chk(ack == 1'b0 && n_rx == r0, "R3 ignored after mismatch", {ack, 8'(n_rx - r0)}, 0);
      end
      s0 = n_stop;
      do_stop();
      chk(n_stop == s0 + 1, "R1 stop pulse", n_stop - s0, 1);
    end

    // R8 no response after stop without a new start
    strap = 3'b000;
    send_byte(8'hAA, ack);
    chk(ack == 1'b0, "R8 silent after stop", ack, 0);
    do_stop();

    // R6 / R7 read with master ack then nack
    txb = 8'h5C;
    t0 = n_txl;
    do_start();
    send_byte(8'hAB, ack);
    chk(ack == 1'b1 && last_rd == 1'b1 && last_blk == 3'b101, "R4 read direction", {ack, last_rd, last_blk}, 5'b11101);
    read_byte(1'b1, d, st);
    chk(d == 8'h5C, "R6 first read word", d, 8'h5C);
    chk(st, "R6 data stable while clock high", st, 1);
    txb = 8'hC3;
    read_byte(1'b0, d, st);
    chk(d == 8'hC3 && n_txl == t0 + 2, "R7 next word after master ack", d, 8'hC3);
    read_byte(1'b0, d, st);
    chk(d == 8'hFF, "R7 released after master nack", d, 8'hFF);
    do_stop();

    // R9 start inside a word
    r0 = n_rx;
    do_start();
    for (int i = 0; i < 3; i++) begin
      sda_m = i[0]; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(4);
    end
    do_start();
    send_byte(8'hAA, ack);
    chk(ack == 1'b1, "R9 device word after restart", ack, 1);
    send_byte(8'h3C, ack);
    chk(ack == 1'b1 && last_rx == 8'h3C && n_rx == r0 + 1, "R9 word after restart", last_rx, 8'h3C);
    do_stop();

    // R10 one-clock glitch on data while clock high
    s0 = n_start; r0 = n_stop;
    tick(HALF);
    sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(HALF);
    chk(n_start == s0 && n_stop == r0, "R10 glitch filtered", (n_start - s0) + (n_stop - r0), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule